// File: doc/BRIEF.md
# CAN Controller Command Register Decoder

This block sits behind the byte-wide CPU port of a stand-alone CAN controller and handles writes to the command register, which lives at one fixed address. An accepted write is turned into one-cycle action strobes (release of the receive buffer, clearing of the data-overrun condition) and into a held transmit request. The transmit request carries a two-bit mode, resolved from the combination of bits written: normal, single-shot (no retry after error or lost arbitration), self-reception, or single-shot self-reception. The request stays up until the transmitter reports its transmit status, or until an abort arrives before the frame has started.

The register cannot be read: every CPU read returns zero. The core clock `clk` runs at the oscillator rate, and the transfer layer runs at half of it. Two command writes must therefore be at least `MIN_GAP` clock cycles apart. A write that comes too soon is dropped and a sticky `spacing_err` flag is raised.

A small tracking state machine holds the request. Its states are:

- `TRK_IDLE`: nothing queued.
- `TRK_PENDING`: request queued, frame not started.
- `TRK_ACTIVE`: frame on the bus.

Its transitions are:

- IDLE to PENDING: on a queueing write.
- PENDING to IDLE: on an abort or on transmit status.
- PENDING to ACTIVE: on `tx_started`.
- ACTIVE to IDLE: on transmit status.

Top module: `can_cmd_decoder`

## Requirements
- R1: Any CPU read returns `bus_rdata` = 8'h00, including a read of the command address (`CMD_ADDR`, default 1) after any write.
- R2: An accepted command write with bit 0 set and bit 1 clear raises `tx_req` in the cycle after the write, with `tx_mode` = 2'b00 (normal). Bit 4 is ignored in this case.
- R3: Bits 0 and 1 written together raise `tx_req` with `tx_mode` = 2'b01 (single-shot), whatever the value of bit 4.
- R4: Bits 4 and 1 written together, with bit 0 clear, raise `tx_req` with `tx_mode` = 2'b11 (single-shot self-reception).
- R5: Bit 4 written alone (bits 0 and 1 clear) raises `tx_req` with `tx_mode` = 2'b10 (self-reception).
- R6: `tx_req` drops in the same cycle in which `tx_status` is high, and the state returns to idle. `tx_mode` reads 2'b00 whenever `tx_req` is low.
- R7: Bit 1 written alone cancels a request that is pending but not yet started. Once `tx_started` has been seen, an abort has no effect.
- R8: Bit 2 gives a single-cycle `release_pulse`, and bit 3 gives a single-cycle `clr_ovr_pulse`, both in the cycle after the write. Both bits may be set in the same write.
- R9: A command write that arrives fewer than `MIN_GAP` (default 2) cycles after the previous accepted one is ignored and sets `spacing_err`, which stays high until reset. A write exactly `MIN_GAP` cycles later is accepted.
- R10: Bits 5 to 7 have no effect, and writes to other addresses have no effect.
- R11: While a request is held, further transmit writes neither re-queue nor change `tx_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | CPU register address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe |
| bus_rdata | output | 8 | CPU read data, always zero |
| tx_started | input | 1 | Transmitter has begun sending the queued frame |
| tx_status | input | 1 | Transmit status from transmitter (frame done) |
| tx_req | output | 1 | Held transmission request |
| tx_mode | output | 2 | Bit 0: no retry; bit 1: self-reception |
| release_pulse | output | 1 | One-cycle receive buffer release |
| clr_ovr_pulse | output | 1 | One-cycle clear of the data-overrun condition |
| spacing_err | output | 1 | Sticky flag for a command write that came too soon |

## Verification
The assertions check the following on every cycle:

- `tx_status` always forces `tx_req` low.
- `tx_mode` is zero while no request is held, and stays stable while a request is held.
- The strobes never last two cycles.
- `spacing_err` never falls.
- A request can only rise right after a CPU write.

The bench scenarios are needed for the rest:

- The bit-combination mapping to each mode.
- Abort before and after the frame start.
- The exact spacing boundary.
- Reads returning zero.
- The lack of effect of reserved bits and foreign addresses.

// File: rtl/can_cmd_pkg.sv
package can_cmd_pkg;

    typedef enum logic [1:0] {
        TXM_NORMAL      = 2'b00,
        TXM_SINGLE      = 2'b01,
        TXM_SELF        = 2'b10,
        TXM_SINGLE_SELF = 2'b11
    } tx_mode_e;

    typedef enum logic [1:0] {
        TRK_IDLE    = 2'd0,
        TRK_PENDING = 2'd1,
        TRK_ACTIVE  = 2'd2
    } trk_state_e;

    typedef struct packed {
        logic     queue;
        tx_mode_e mode;
        logic     abort;
        logic     release_buf;
        logic     clr_ovr;
    } cmd_decode_t;

    localparam int BIT_TR  = 0;
    localparam int BIT_AT  = 1;
    localparam int BIT_RRB = 2;
    localparam int BIT_CDO = 3;
    localparam int BIT_SRR = 4;

endpackage

// File: rtl/can_cmd_pacer.sv
module can_cmd_pacer #(
    parameter int MIN_GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    output logic accept,
    output logic spacing_err
);
    localparam int CNT_W = (MIN_GAP > 1) ? $clog2(MIN_GAP) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(MIN_GAP - 1);

    logic [CNT_W-1:0] guard_q;

    assign accept = cmd_wr && (guard_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            guard_q     <= '0;
            spacing_err <= 1'b0;
        end else begin
            if (accept) begin
                guard_q <= RELOAD;
            end else if (guard_q != '0) begin
                guard_q <= guard_q - 1'b1;
            end
            if (cmd_wr && !accept) begin
                spacing_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/can_cmd_resolve.sv
module can_cmd_resolve
    import can_cmd_pkg::*;
(
    input  logic [7:0]  wdata,
    output cmd_decode_t dec
);
    logic tr, at, srr;
    logic [2:0] unused_reserved;

    assign tr  = wdata[BIT_TR];
    assign at  = wdata[BIT_AT];
    assign srr = wdata[BIT_SRR];
    assign unused_reserved = wdata[7:5];

    always_comb begin
        dec             = '0;
        dec.release_buf = wdata[BIT_RRB];
        dec.clr_ovr     = wdata[BIT_CDO];
        unique casez ({srr, at, tr})
            3'b?11:  begin dec.queue = 1'b1; dec.mode = TXM_SINGLE;      end
            3'b110:  begin dec.queue = 1'b1; dec.mode = TXM_SINGLE_SELF; end
            3'b?01:  begin dec.queue = 1'b1; dec.mode = TXM_NORMAL;      end
            3'b100:  begin dec.queue = 1'b1; dec.mode = TXM_SELF;        end
            3'b010:  dec.abort = 1'b1;
            default: dec.queue = 1'b0;
        endcase
    end
endmodule

// File: rtl/can_cmd_tracker.sv
module can_cmd_tracker
    import can_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept,
    input  cmd_decode_t dec,
    input  logic        tx_started,
    input  logic        tx_status,
    output logic        tx_req,
    output tx_mode_e    tx_mode
);
    trk_state_e state_q, state_d;
    tx_mode_e   mode_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE: begin
                if (accept && dec.queue) state_d = TRK_PENDING;
            end
            TRK_PENDING: begin
                if (tx_status || (accept && dec.abort)) state_d = TRK_IDLE;
                else if (tx_started)                    state_d = TRK_ACTIVE;
            end
            TRK_ACTIVE: begin
                if (tx_status) state_d = TRK_IDLE;
            end
            default: state_d = TRK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            mode_q  <= TXM_NORMAL;
        end else begin
            state_q <= state_d;
            if (state_q == TRK_IDLE && accept && dec.queue) begin
                mode_q <= dec.mode;
            end
        end
    end

    always_comb begin
        tx_req  = (state_q != TRK_IDLE) && !tx_status;
        tx_mode = tx_req ? mode_q : TXM_NORMAL;
    end
endmodule

// File: rtl/can_cmd_decoder.sv
module can_cmd_decoder
    import can_cmd_pkg::*;
#(
    parameter int          ADDR_W   = 5,
    parameter int          MIN_GAP  = 2,
    parameter logic [4:0]  CMD_ADDR = 5'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              tx_started,
    input  logic              tx_status,
    output logic              tx_req,
    output logic [1:0]        tx_mode,
    output logic              release_pulse,
    output logic              clr_ovr_pulse,
    output logic              spacing_err
);
    localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_ADDR);

    logic        cmd_wr, accept, unused_rd;
    cmd_decode_t dec;
    tx_mode_e    mode_w;

    assign cmd_wr    = bus_wr && (bus_addr == CMD_A);
    assign unused_rd = bus_rd;
    assign bus_rdata = 8'h00;

    can_cmd_pacer #(.MIN_GAP(MIN_GAP)) u_pacer (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr),
        .accept(accept), .spacing_err(spacing_err)
    );

    can_cmd_resolve u_resolve (.wdata(bus_wdata), .dec(dec));

    can_cmd_tracker u_tracker (
        .clk(clk), .rst_n(rst_n), .accept(accept), .dec(dec),
        .tx_started(tx_started), .tx_status(tx_status),
        .tx_req(tx_req), .tx_mode(mode_w)
    );

    assign tx_mode = mode_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            release_pulse <= 1'b0;
            clr_ovr_pulse <= 1'b0;
        end else begin
            release_pulse <= accept && dec.release_buf;
            clr_ovr_pulse <= accept && dec.clr_ovr;
        end
    end
endmodule

// File: rtl/can_cmd_checker.sv
module can_cmd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       tx_status,
    input logic       tx_req,
    input logic [1:0] tx_mode,
    input logic       release_pulse,
    input logic       clr_ovr_pulse,
    input logic       spacing_err
);
    AST_STATUS_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_status |-> !tx_req); // R6
    AST_MODE_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |-> (tx_mode == 2'b00)); // R6
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> (!tx_req || $stable(tx_mode))); // R11
    AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |=> !release_pulse); // R8
    AST_CLR_OVR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ovr_pulse |=> !clr_ovr_pulse); // R8
    AST_SPACING_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        spacing_err |=> spacing_err); // R9
    AST_REQ_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_req) |-> $past(bus_wr)); // R2
endmodule

bind can_cmd_decoder can_cmd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .tx_status(tx_status),
    .tx_req(tx_req), .tx_mode(tx_mode), .release_pulse(release_pulse),
    .clr_ovr_pulse(clr_ovr_pulse), .spacing_err(spacing_err)
);

// File: tb/test_can_cmd_decoder.sv
module test_can_cmd_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       tx_started = 1'b0, tx_status = 1'b0;
    logic       tx_req;
    logic [1:0] tx_mode;
    logic       release_pulse, clr_ovr_pulse, spacing_err;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    can_cmd_decoder i_can_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tx_started(tx_started), .tx_status(tx_status), .tx_req(tx_req),
        .tx_mode(tx_mode), .release_pulse(release_pulse),
        .clr_ovr_pulse(clr_ovr_pulse), .spacing_err(spacing_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_tx(input string req, input bit r, input int m);
        check(tx_req == r, {req, " tx_req"}, int'(tx_req), int'(r));
        check(int'(tx_mode) == m, {req, " tx_mode"}, int'(tx_mode), m);
    endtask

    task automatic wr_cmd(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic finish_tx();
        @(negedge clk); tx_status = 1'b1;
        @(negedge clk); tx_status = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        expect_tx("R6 reset", 1'b0, 0);
        check(!release_pulse && !clr_ovr_pulse, "R8 reset strobes",
              int'({release_pulse, clr_ovr_pulse}), 0);
        check(!spacing_err, "R9 reset err", int'(spacing_err), 0);
    endtask

    task automatic t_read();
        wr_cmd(5'd1, 8'h1F);
        @(negedge clk);
        bus_addr = 5'd1; bus_rd = 1'b1;
        #1 check(bus_rdata == 8'h00, "R1 read cmd", int'(bus_rdata), 0);
        @(negedge clk); bus_rd = 1'b0;
        finish_tx();
    endtask

    task automatic t_normal();
        wr_cmd(5'd1, 8'h01);
        expect_tx("R2 bit0", 1'b1, 0);
        finish_tx();
        wr_cmd(5'd1, 8'h11);
        expect_tx("R2 bit0+bit4", 1'b1, 0);
        finish_tx();
    endtask

    task automatic t_single();
        wr_cmd(5'd1, 8'h03);
        expect_tx("R3 bits0,1", 1'b1, 1);
        finish_tx();
        wr_cmd(5'd1, 8'h13);
        expect_tx("R3 bits0,1,4", 1'b1, 1);
        finish_tx();
    endtask

    task automatic t_self();
        wr_cmd(5'd1, 8'h12);
        expect_tx("R4 bits1,4", 1'b1, 3);
        finish_tx();
        wr_cmd(5'd1, 8'h10);
        expect_tx("R5 bit4", 1'b1, 2);
        finish_tx();
    endtask

    task automatic t_status();
        wr_cmd(5'd1, 8'h01);
        tx_started = 1'b1;
        @(negedge clk); tx_started = 1'b0;
        expect_tx("R6 active", 1'b1, 0);
        tx_status = 1'b1;
        #1 expect_tx("R6 same cycle", 1'b0, 0);
        @(negedge clk); tx_status = 1'b0;
        #1 expect_tx("R6 after", 1'b0, 0);
    endtask

    task automatic t_abort();
        wr_cmd(5'd1, 8'h01);
        wr_cmd(5'd1, 8'h02);
        expect_tx("R7 abort pending", 1'b0, 0);
        wr_cmd(5'd1, 8'h03);
        tx_started = 1'b1;
        @(negedge clk); tx_started = 1'b0;
        wr_cmd(5'd1, 8'h02);
        expect_tx("R7 abort after start", 1'b1, 1);
        finish_tx();
    endtask

    task automatic t_strobes();
        wr_cmd(5'd1, 8'h04);
        check(release_pulse && !clr_ovr_pulse, "R8 release", int'({release_pulse, clr_ovr_pulse}), 2);
        @(negedge clk);
        check(!release_pulse, "R8 release one cycle", int'(release_pulse), 0);
        wr_cmd(5'd1, 8'h0C);
        check(release_pulse && clr_ovr_pulse, "R8 both", int'({release_pulse, clr_ovr_pulse}), 3);
        expect_tx("R8 no tx", 1'b0, 0);
        @(negedge clk);
    endtask

    task automatic t_reserved();
        wr_cmd(5'd1, 8'hE0);
        expect_tx("R10 reserved", 1'b0, 0);
        check(!release_pulse && !clr_ovr_pulse, "R10 reserved strobes",
              int'({release_pulse, clr_ovr_pulse}), 0);
        wr_cmd(5'd2, 8'h05);
        expect_tx("R10 other addr", 1'b0, 0);
        check(!release_pulse, "R10 other addr strobe", int'(release_pulse), 0);
        @(negedge clk);
    endtask

    task automatic t_busy();
        wr_cmd(5'd1, 8'h03);
        wr_cmd(5'd1, 8'h10);
        expect_tx("R11 held mode", 1'b1, 1);
        finish_tx();
    endtask

    task automatic t_spacing();
        check(!spacing_err, "R9 no err on legal gap", int'(spacing_err), 0);
        @(negedge clk);
        bus_addr = 5'd1; bus_wdata = 8'h04; bus_wr = 1'b1;
        @(negedge clk);
        bus_wdata = 8'h08;
        check(release_pulse, "R9 first accepted", int'(release_pulse), 1);
        @(negedge clk);
        bus_wr = 1'b0;
        check(!clr_ovr_pulse, "R9 early write ignored", int'(clr_ovr_pulse), 0);
        check(spacing_err, "R9 err set", int'(spacing_err), 1);
        wr_cmd(5'd1, 8'h08);
        check(clr_ovr_pulse, "R9 later write accepted", int'(clr_ovr_pulse), 1);
        check(spacing_err, "R9 err sticky", int'(spacing_err), 1);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read();
        t_normal();
        t_single();
        t_self();
        t_status();
        t_abort();
        t_strobes();
        t_reserved();
        t_busy();
        t_spacing();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end
endmodule